// File: doc/BRIEF.md
# Configurable 8-bit GPIO port

This block is one general-purpose I/O port of eight pins, controlled through four byte-wide registers on a simple register bus. Software sets a data latch, a per-pin direction, a pull request and an open-drain select. From these the block produces the value and the output enable for each pad, and a pull-up or pull-down request for each pad. The actual pull and open-drain pad behaviour is outside this block; it only raises the control lines.

Reading the data register returns a mix. Pins that are outputs give back the latch. Pins that are inputs give back the pad level after it has passed through a two-flop synchronizer. A parameter selects one of two direction modes. In the first, every pin has its own direction bit. In the second, bit 0 of the direction register sets the direction of the whole port. A per-pin parameter mask decides whether each pin's pull is a pull-down or a pull-up. A second mask says which bits of the pull register exist.

Top module: `gpio_port8`

## Requirements
- R1: After reset all four registers read 0. Every pin is an input, no pad is enabled, and no pull is requested.
- R2: Register offsets are 0 for data, 1 for direction, 2 for pull and 3 for open-drain select. A direction bit of 1 makes its pin an output and 0 makes it an input. An output pin with open-drain select 0 has `pad_oe`=1 and `pad_o` equal to its latch bit. An input pin has `pad_oe`=0.
- R3: A read at offset 0 returns the latch bit for output pins and the synchronized pad level for input pins. A change on `pin_in` becomes visible in the read after the second rising clock edge.
- R4: A write to offset 0 always updates the latch. Input pins stay undriven. The written value appears on `pad_o` once the pin is turned into an output.
- R5: A pin with its pull bit set requests a pull only while it is an input. The request goes to `pd_req` if its `PULL_DOWN_MASK` bit is 1 and to `pu_req` otherwise. An output pin never requests a pull, even while it floats in open-drain mode.
- R6: For an output pin with open-drain select 1, `pad_o` is 0. `pad_oe` is 1 only while the latch bit is 0.
- R7: With `WHOLE_DIR`=1, bit 0 of the direction register sets the direction of all pins. Direction bits 1 to 7 are not stored and read back as 0.
- R8: Pull register bits that are clear in `PULL_USED_MASK` read back as 0 and never cause a pull request.
- R9: A write takes effect at the rising clock edge where `wr_en` is sampled high. In the write cycle itself, the combinational read of that register still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register offset |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Combinational read data |
| pin_in | input | WIDTH | Sampled pad levels |
| pad_o | output | WIDTH | Pad output value |
| pad_oe | output | WIDTH | Pad output enable |
| pu_req | output | WIDTH | Pull-up request |
| pd_req | output | WIDTH | Pull-down request |

## Verification
Two things can fall in the same cycle: a change of a pad level, and a read of the data register whose per-pin source is picked by the direction register. The bench sets the low nibble as inputs and the high nibble as outputs. It then changes `pin_in` and reads offset 0 one cycle later and again two cycles later. The first read must show the latch in the high nibble and the old pad level in the low nibble. The second read must show the new pad level. A separate case reads a register in the same cycle as its write strobe and expects the old contents.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GPIO_ADDR_W = 2;

  typedef enum logic [GPIO_ADDR_W-1:0] {
    REG_DATA  = 2'd0,
    REG_DIR   = 2'd1,
    REG_PULL  = 2'd2,
    REG_ODSEL = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int               WIDTH          = 8,
  parameter bit               WHOLE_DIR      = 1'b0,
  parameter logic [WIDTH-1:0] PULL_USED_MASK = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [GPIO_ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]       wdata,
  output logic [WIDTH-1:0]       latch_q,
  output logic [WIDTH-1:0]       dir_q,
  output logic [WIDTH-1:0]       pull_q,
  output logic [WIDTH-1:0]       od_q
);
  localparam logic [WIDTH-1:0] DIR_MASK = WHOLE_DIR ? WIDTH'(1) : '1;

  logic we_latch, we_dir, we_pull, we_od;
  logic [WIDTH-1:0] latch_nxt, dir_nxt, pull_nxt, od_nxt;

  always_comb begin
    we_latch  = wr_en && (addr == REG_DATA);
    we_dir    = wr_en && (addr == REG_DIR);
    we_pull   = wr_en && (addr == REG_PULL);
    we_od     = wr_en && (addr == REG_ODSEL);
    latch_nxt = wdata;
    dir_nxt   = wdata & DIR_MASK;
    pull_nxt  = wdata & PULL_USED_MASK;
    od_nxt    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (we_latch) latch_q <= latch_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (we_dir) dir_q <= dir_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pull_q <= '0;
    else if (we_pull) pull_q <= pull_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     od_q <= '0;
    else if (we_od) od_q <= od_nxt;
  end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
  parameter bit PULL_DOWN = 1'b0
) (
  input  logic is_out,
  input  logic latch,
  input  logic od_sel,
  input  logic pull_on,
  output logic pad_o,
  output logic pad_oe,
  output logic pu,
  output logic pd
);
  logic pull_act;

  always_comb begin
    pad_oe   = is_out & ~(od_sel & latch);
    pad_o    = latch & ~od_sel;
    pull_act = pull_on & ~is_out;
    pu       = pull_act & ~PULL_DOWN;
    pd       = pull_act & PULL_DOWN;
  end
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio_pkg::*;
#(
  parameter int               WIDTH          = 8,
  parameter bit               WHOLE_DIR      = 1'b0,
  parameter logic [WIDTH-1:0] PULL_DOWN_MASK = '0,
  parameter logic [WIDTH-1:0] PULL_USED_MASK = '1,
  parameter int               SYNC_STAGES    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [GPIO_ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]       wdata,
  output logic [WIDTH-1:0]       rdata,
  input  logic [WIDTH-1:0]       pin_in,
  output logic [WIDTH-1:0]       pad_o,
  output logic [WIDTH-1:0]       pad_oe,
  output logic [WIDTH-1:0]       pu_req,
  output logic [WIDTH-1:0]       pd_req
);
  logic             rst_sn;
  logic [WIDTH-1:0] latch_q, dir_q, pull_q, od_q;
  logic [WIDTH-1:0] dir_eff, pin_sync;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  gpio_regs #(
    .WIDTH          (WIDTH),
    .WHOLE_DIR      (WHOLE_DIR),
    .PULL_USED_MASK (PULL_USED_MASK)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .pull_q  (pull_q),
    .od_q    (od_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (pin_in),
    .q     (pin_sync)
  );

  generate
    if (WHOLE_DIR) begin : g_dir_whole
      assign dir_eff = {WIDTH{dir_q[0]}};
    end else begin : g_dir_bit
      assign dir_eff = dir_q;
    end
  endgenerate

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    gpio_pin_ctl #(.PULL_DOWN(PULL_DOWN_MASK[g])) u_pin (
      .is_out  (dir_eff[g]),
      .latch   (latch_q[g]),
      .od_sel  (od_q[g]),
      .pull_on (pull_q[g]),
      .pad_o   (pad_o[g]),
      .pad_oe  (pad_oe[g]),
      .pu      (pu_req[g]),
      .pd      (pd_req[g])
    );
  end

  always_comb begin
    case (addr)
      REG_DATA:  rdata = (dir_eff & latch_q) | (~dir_eff & pin_sync);
      REG_DIR:   rdata = dir_q;
      REG_PULL:  rdata = pull_q;
      default:   rdata = od_q;
    endcase
  end
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk #(
  parameter int WIDTH     = 8,
  parameter bit WHOLE_DIR = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sn,
  input logic             wr_en,
  input logic [WIDTH-1:0] pad_o,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pu_req,
  input logic [WIDTH-1:0] pd_req,
  input logic [WIDTH-1:0] od_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sn) |-> (pad_oe == '0 && pu_req == '0 && pd_req == '0));

  // R9
  oe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(pad_oe));

  // R5
  no_pull_on_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & (pu_req | pd_req)) == '0);

  // R5
  pull_one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_req & pd_req) == '0);

  // R6
  od_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & od_q & pad_o) == '0);

  generate
    if (WHOLE_DIR) begin : g_whole
      // R7
      whole_dir_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~od_q) == '0) || ((pad_oe & ~od_q) == ~od_q));
    end
  endgenerate
endmodule

bind gpio_port8 gpio_port8_chk #(.WIDTH(WIDTH), .WHOLE_DIR(WHOLE_DIR)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rst_sn (rst_sn),
  .wr_en  (wr_en),
  .pad_o  (pad_o),
  .pad_oe (pad_oe),
  .pu_req (pu_req),
  .pd_req (pd_req),
  .od_q   (od_q)
);

// File: tb/test_gpio_port8.sv
module test_gpio_port8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, pin_in;
  logic [7:0] rdata, pad_o, pad_oe, pu_req, pd_req;
  logic [7:0] rdata_w, pad_o_w, pad_oe_w, pu_req_w, pd_req_w;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port8 #(.PULL_DOWN_MASK(8'h33), .PULL_USED_MASK(8'h7F)) i_gpio_port8 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pad_o(pad_o), .pad_oe(pad_oe),
    .pu_req(pu_req), .pd_req(pd_req));

  gpio_port8 #(.WHOLE_DIR(1'b1)) i_gpio_port8_w (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_w), .pin_in(pin_in), .pad_o(pad_o_w), .pad_oe(pad_oe_w),
    .pu_req(pu_req_w), .pd_req(pd_req_w));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    addr = a;
    #1;
  endtask

  task automatic set_pin(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pu_req", pu_req, 8'h00);
    chk("R1 pd_req", pd_req, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a));
      chk("R1 reg read", rdata, 8'h00);
    end
  endtask

  task automatic t_regs_rw;
    wr(2'd1, 8'hA5); rd(2'd1); chk("R2 dir readback", rdata, 8'hA5);
    wr(2'd3, 8'h3C); rd(2'd3); chk("R2 odsel readback", rdata, 8'h3C);
    wr(2'd2, 8'hFF); rd(2'd2); chk("R8 unused pull bit reads 0", rdata, 8'h7F);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_push_pull;
    wr(2'd0, 8'h5A); wr(2'd1, 8'hF0);
    chk("R2 pad_oe", pad_oe, 8'hF0);
    chk("R2 pad_o", pad_o, 8'h5A);
  endtask

  // both read sources in one access, around a pad change
  task automatic t_read_mix;
    wr(2'd0, 8'h5A); wr(2'd1, 8'hF0);
    set_pin(8'h00);
    rd(2'd0);
    @(negedge clk); pin_in = 8'h33;
    @(negedge clk); #1;
    chk("R3 one edge after pad change", rdata, 8'h50);
    @(negedge clk); #1;
    chk("R3 two edges after pad change", rdata, 8'h53);
  endtask

  task automatic t_input_write;
    wr(2'd1, 8'h00); set_pin(8'h33);
    wr(2'd0, 8'hC3);
    chk("R4 input stays undriven", pad_oe, 8'h00);
    rd(2'd0); chk("R4 input read shows pad", rdata, 8'h33);
    wr(2'd1, 8'hFF);
    chk("R4 latched value drives", pad_o, 8'hC3);
    chk("R4 now enabled", pad_oe, 8'hFF);
    rd(2'd0); chk("R3 output read shows latch", rdata, 8'hC3);
  endtask

  task automatic t_pull;
    wr(2'd1, 8'h0F); wr(2'd2, 8'hFF);
    chk("R5 pd on inputs", pd_req, 8'h30);
    chk("R5 pu on inputs", pu_req, 8'h40);
    wr(2'd1, 8'h00);
    chk("R5 pd all inputs", pd_req, 8'h33);
    chk("R8 pu, bit 7 unused", pu_req, 8'h4C);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_open_drain;
    wr(2'd0, 8'h05); wr(2'd3, 8'h0F); wr(2'd2, 8'hFF); wr(2'd1, 8'hFF);
    chk("R6 oe od low nibble", pad_oe, 8'hFA);
    chk("R6 pad_o", pad_o, 8'h00);
    chk("R5 no pull on floating od output", pu_req | pd_req, 8'h00);
    rd(2'd0); chk("R3 od output read shows latch", rdata, 8'h05);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_write_timing;
    wr(2'd1, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h81;
    #1; chk("R9 old value in write cycle", rdata, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;
    #1; chk("R9 new value after edge", rdata, 8'h81);
    chk("R9 oe after edge", pad_oe, 8'h81);
  endtask

  task automatic t_whole;
    wr(2'd3, 8'h00); wr(2'd0, 8'hA5); set_pin(8'h33);
    wr(2'd1, 8'hFE);
    chk("R7 bit0 clear: all inputs", pad_oe_w, 8'h00);
    rd(2'd1); chk("R7 dir bits 1-7 read 0", rdata_w, 8'h00);
    rd(2'd0); chk("R7 inputs read pad", rdata_w, 8'h33);
    wr(2'd1, 8'h01);
    chk("R7 bit0 set: all outputs", pad_oe_w, 8'hFF);
    chk("R7 pad_o", pad_o_w, 8'hA5);
    rd(2'd0); chk("R7 outputs read latch", rdata_w, 8'hA5);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    t_regs_rw();
    t_push_pull();
    t_read_mix();
    t_input_write();
    t_pull();
    t_open_drain();
    t_write_timing();
    t_whole();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule